// File: doc/BRIEF.md
# Complex Fixed-Point Multiply-Accumulate Unit

This unit is the inner arithmetic of a complex matrix product. Each clock it can take one multiplicand word and one multiplier word. Each word holds a complex number made of two 16-bit components. The unit forms their complex product and rescales it to the accumulator's fixed-point format. It then adds the result to a running complex sum that it keeps internally.

The multiplicand components carry 14 fraction bits and are limited to the range -1.0 to +1.0. The multiplier and the sum share one common format. Each partial product is therefore shifted right by 14 before it is added. A clear flag marks the first term of a new output element: that term replaces the sum instead of adding to it.

The datapath is a three-stage pipeline with no stalls. The first stage registers the unpacked operands. The second forms four real products at full 32-bit precision. The third combines the products, realigns the result and updates the accumulator. The controller streams operand pairs in and takes the finished sum after the last term of each element has come out.

Top module: `cmac_unit`

## Requirements
- R1: Operand words `a_word` and `b_word` and the result `acc_word` are packed the same way: bits [31:16] hold the real component and bits [15:0] hold the imaginary component, each a 16-bit two's-complement value.
- R2: The real term added for an operand pair is the exact value ar*br − ai*bi, shifted right arithmetically by 14 (rounding toward minus infinity), of which the low 16 bits are kept.
- R3: The imaginary term is the exact value ar*bi + ai*br, shifted and truncated in the same way as in R2.
- R4: Multiplicand components lie in the range [-16384, +16384]. This is 14 fraction bits, covering ±1.0. Both ends of the range are accepted and give exact results.
- R5: An accepted pair (`in_valid`=1, `clear`=0) adds its terms to the accumulator components, wrapping modulo 2^16.
- R6: An accepted pair with `clear`=1 loads the accumulator with its own terms, discarding the previous sum.
- R7: `clear` sampled while `in_valid` is 0 has no effect on the sum.
- R8: If `in_valid` is sampled high at rising edge k, `out_valid` is high, with the updated sum on `acc_word`, in the cycle after edge k+2. Back-to-back pairs give back-to-back results.
- R9: While `out_valid` is low, `acc_word` keeps the last sum produced.
- R10: While `rst_n` is low, `out_valid` is 0 and `acc_word` is 0.
- R11: Operand values presented while `in_valid` is 0 do not change the sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| clear | input | 1 | This pair starts a new sum (qualified by in_valid) |
| a_word | input | 32 | Packed complex multiplicand, 14 fraction bits |
| b_word | input | 32 | Packed complex multiplier |
| out_valid | output | 1 | Updated sum present on acc_word |
| acc_word | output | 32 | Packed complex running sum |

## Verification
On every cycle, the assertions check the three-cycle valid latency and that the sum holds still while no result is valid. They also check the input contract on the multiplicand range, and that the partial products and the combined sums stay inside the bounds that contract implies. The exact arithmetic cannot be checked that way. This covers the floor rounding of negative products, wrap on overflow, and the difference between a clearing term and an accumulating term, including a clear with no valid operand. Only the bench's sweeps show these, by comparing each result with a value computed from integer arithmetic. The sweeps cover every combination of extreme and mixed component values.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

    // Control bits that travel alongside the data through every stage.
    typedef struct packed {
        logic valid;
        logic clear;
    } cmac_ctl_t;

    // Product lane order inside the multiply stage.
    localparam int LANE_RR = 0;   // ar * br
    localparam int LANE_II = 1;   // ai * bi
    localparam int LANE_RI = 2;   // ar * bi
    localparam int LANE_IR = 3;   // ai * br
    localparam int NUM_LANES = 4;

endpackage

// File: rtl/cmac_unpack.sv
module cmac_unpack
    import cmac_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AFRAC = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 clear,
    input  logic [2*DW-1:0]      a_word,
    input  logic [2*DW-1:0]      b_word,
    output cmac_ctl_t            ctl_o,
    output logic signed [DW-1:0] ar_o,
    output logic signed [DW-1:0] ai_o,
    output logic signed [DW-1:0] br_o,
    output logic signed [DW-1:0] bi_o
);

    localparam int WW   = 2 * DW;
    localparam int AONE = 1 << AFRAC;

    typedef struct packed {
        cmac_ctl_t            ctl;
        logic signed [DW-1:0] ar;
        logic signed [DW-1:0] ai;
        logic signed [DW-1:0] br;
        logic signed [DW-1:0] bi;
    } op_stage_t;

    op_stage_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.ctl.valid = in_valid;
        st_d.ctl.clear = in_valid & clear;
        if (in_valid) begin
            st_d.ar = $signed(a_word[WW-1:DW]);
            st_d.ai = $signed(a_word[DW-1:0]);
            st_d.br = $signed(b_word[WW-1:DW]);
            st_d.bi = $signed(b_word[DW-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o = st_q.ctl;
    assign ar_o  = st_q.ar;
    assign ai_o  = st_q.ai;
    assign br_o  = st_q.br;
    assign bi_o  = st_q.bi;

    AST_A_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ($signed(a_word[WW-1:DW]) >= -AONE && $signed(a_word[WW-1:DW]) <= AONE &&
                      $signed(a_word[DW-1:0])  >= -AONE && $signed(a_word[DW-1:0])  <= AONE)); // R4

endmodule

// File: rtl/cmac_mult.sv
module cmac_mult
    import cmac_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AFRAC = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cmac_ctl_t            ctl_i,
    input  logic signed [DW-1:0] ar_i,
    input  logic signed [DW-1:0] ai_i,
    input  logic signed [DW-1:0] br_i,
    input  logic signed [DW-1:0] bi_i,
    output cmac_ctl_t            ctl_o,
    output logic [NUM_LANES-1:0][2*DW-1:0] prod_o
);

    localparam int    PW   = 2 * DW;
    localparam longint PBND = 64'sd1 << (AFRAC + DW - 1);

    typedef struct packed {
        cmac_ctl_t                     ctl;
        logic [NUM_LANES-1:0][PW-1:0]  p;
    } mul_stage_t;

    mul_stage_t st_d, st_q;

    logic signed [DW-1:0] lhs [NUM_LANES];
    logic signed [DW-1:0] rhs [NUM_LANES];
    logic signed [PW-1:0] prod_c [NUM_LANES];

    assign lhs[LANE_RR] = ar_i;  assign rhs[LANE_RR] = br_i;
    assign lhs[LANE_II] = ai_i;  assign rhs[LANE_II] = bi_i;
    assign lhs[LANE_RI] = ar_i;  assign rhs[LANE_RI] = bi_i;
    assign lhs[LANE_IR] = ai_i;  assign rhs[LANE_IR] = br_i;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic signed [PW-1:0] lhs_ext, rhs_ext;
        assign lhs_ext   = PW'(lhs[g]);
        assign rhs_ext   = PW'(rhs[g]);
        assign prod_c[g] = lhs_ext * rhs_ext;
    end

    always_comb begin
        st_d     = st_q;
        st_d.ctl = ctl_i;
        if (ctl_i.valid) begin
            for (int k = 0; k < NUM_LANES; k++) begin
                st_d.p[k] = prod_c[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o  = st_q.ctl;
    assign prod_o = st_q.p;

    AST_PROD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctl.valid |-> (longint'($signed(st_q.p[LANE_RR])) <= PBND &&
                            longint'($signed(st_q.p[LANE_RR])) >= -PBND &&
                            longint'($signed(st_q.p[LANE_IR])) <= PBND &&
                            longint'($signed(st_q.p[LANE_IR])) >= -PBND)); // R4

endmodule

// File: rtl/cmac_accum.sv
module cmac_accum
    import cmac_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AFRAC = 14
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  cmac_ctl_t                      ctl_i,
    input  logic [NUM_LANES-1:0][2*DW-1:0] prod_i,
    output logic                           valid_o,
    output logic [DW-1:0]                  acc_re_o,
    output logic [DW-1:0]                  acc_im_o
);

    localparam int     PW   = 2 * DW;
    localparam longint SBND = 64'sd1 << (AFRAC + DW);

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] re;
        logic [DW-1:0] im;
    } acc_stage_t;

    acc_stage_t st_d, st_q;

    logic signed [PW-1:0] sum_re, sum_im;
    logic [DW-1:0]        term_re, term_im;
    logic [DW-1:0]        base_re, base_im;

    always_comb begin
        sum_re  = $signed(prod_i[LANE_RR]) - $signed(prod_i[LANE_II]);
        sum_im  = $signed(prod_i[LANE_RI]) + $signed(prod_i[LANE_IR]);
        term_re = DW'(sum_re >>> AFRAC);
        term_im = DW'(sum_im >>> AFRAC);
        base_re = ctl_i.clear ? '0 : st_q.re;
        base_im = ctl_i.clear ? '0 : st_q.im;

        st_d       = st_q;
        st_d.valid = ctl_i.valid;
        if (ctl_i.valid) begin
            st_d.re = base_re + term_re;
            st_d.im = base_im + term_im;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o  = st_q.valid;
    assign acc_re_o = st_q.re;
    assign acc_im_o = st_q.im;

    AST_SUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.valid |-> (longint'(sum_re) <= SBND && longint'(sum_re) >= -SBND &&
                         longint'(sum_im) <= SBND && longint'(sum_im) >= -SBND)); // R4

endmodule

// File: rtl/cmac_unit.sv
module cmac_unit
    import cmac_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AFRAC = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            clear,
    input  logic [2*DW-1:0] a_word,
    input  logic [2*DW-1:0] b_word,
    output logic            out_valid,
    output logic [2*DW-1:0] acc_word
);

    localparam int PW = 2 * DW;
    localparam int LATENCY = 3;

    cmac_ctl_t            ctl_s1, ctl_s2;
    logic signed [DW-1:0] ar_s1, ai_s1, br_s1, bi_s1;
    logic [NUM_LANES-1:0][PW-1:0] prod_s2;
    logic [DW-1:0]        acc_re, acc_im;

    cmac_unpack #(.DW(DW), .AFRAC(AFRAC)) u_unpack (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .clear    (clear),
        .a_word   (a_word),
        .b_word   (b_word),
        .ctl_o    (ctl_s1),
        .ar_o     (ar_s1),
        .ai_o     (ai_s1),
        .br_o     (br_s1),
        .bi_o     (bi_s1)
    );

    cmac_mult #(.DW(DW), .AFRAC(AFRAC)) u_mult (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_i  (ctl_s1),
        .ar_i   (ar_s1),
        .ai_i   (ai_s1),
        .br_i   (br_s1),
        .bi_i   (bi_s1),
        .ctl_o  (ctl_s2),
        .prod_o (prod_s2)
    );

    cmac_accum #(.DW(DW), .AFRAC(AFRAC)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_i    (ctl_s2),
        .prod_i   (prod_s2),
        .valid_o  (out_valid),
        .acc_re_o (acc_re),
        .acc_im_o (acc_im)
    );

    assign acc_word = {acc_re, acc_im};

    // Cycles since reset, saturating, so the latency check never looks before reset.
    logic [1:0] warm_d, warm_q;

    always_comb begin
        warm_d = warm_q;
        if (warm_q != 2'(LATENCY)) begin
            warm_d = warm_q + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else begin
            warm_q <= warm_d;
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'(LATENCY)) |-> (out_valid == $past(in_valid, 3))); // R8

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(acc_word)); // R9

endmodule

// File: tb/cmac_unit_bench.sv
`timescale 1ns/1ps
module cmac_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        clear;
    logic [31:0] a_word;
    logic [31:0] b_word;
    logic        out_valid;
    logic [31:0] acc_word;

    always #2 clk = ~clk;

    cmac_unit u_cmac_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .clear     (clear),
        .a_word    (a_word),
        .b_word    (b_word),
        .out_valid (out_valid),
        .acc_word  (acc_word)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Expected outputs in flight: index 2 is due at the next check.
    logic        exp_v   [3];
    logic [31:0] exp_acc [3];
    string       exp_tag [3];
    logic [31:0] model_acc;
    logic [31:0] seed;

    function automatic logic [31:0] model(input logic [31:0] acc, input logic [31:0] a,
                                          input logic [31:0] b, input logic clr);
        longint ar = longint'($signed(a[31:16]));
        longint ai = longint'($signed(a[15:0]));
        longint br = longint'($signed(b[31:16]));
        longint bi = longint'($signed(b[15:0]));
        longint pr = ar * br - ai * bi;
        longint pi = ar * bi + ai * br;
        logic [15:0] tr = 16'(pr >>> 14);
        logic [15:0] ti = 16'(pi >>> 14);
        logic [15:0] r0 = clr ? 16'd0 : acc[31:16];
        logic [15:0] i0 = clr ? 16'd0 : acc[15:0];
        logic [15:0] nr = r0 + tr;
        logic [15:0] ni = i0 + ti;
        return {nr, ni};
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    // Random multiplicand component in [-16384, 16383].
    function automatic logic [15:0] rand_a(input logic [31:0] s);
        int v = int'(s[30:16]) - 16384;
        return 16'(v);
    endfunction

    task automatic step(input logic v, input logic clr, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
        @(negedge clk);
        checks++;
        if (out_valid !== exp_v[2]) begin
            fails++;
            $display("FAIL R8 (%s): out_valid act %0b exp %0b", exp_tag[2], out_valid, exp_v[2]);
        end else if (acc_word !== exp_acc[2]) begin
            fails++;
            $display("FAIL %s: acc_word act %h exp %h", exp_tag[2], acc_word, exp_acc[2]);
        end
        if (v) model_acc = model(model_acc, a, b, clr);
        exp_v[2]   = exp_v[1];   exp_acc[2] = exp_acc[1]; exp_tag[2] = exp_tag[1];
        exp_v[1]   = exp_v[0];   exp_acc[1] = exp_acc[0]; exp_tag[1] = exp_tag[0];
        exp_v[0]   = v;          exp_acc[0] = model_acc;  exp_tag[0] = tag;
        in_valid = v;
        clear    = clr;
        a_word   = a;
        b_word   = b;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, act hung exp done");
        finish_run();
    end

    initial begin
        logic [15:0] aset [5];
        logic [15:0] bset [5];
        aset = '{16'sd16384, -16'sd16384, 16'd0, 16'd1, -16'sd7777};
        bset = '{16'sd32767, -16'sd32768, 16'd0, 16'hFFFF, 16'sd12345};
        seed      = 32'h1234_5678;
        model_acc = '0;
        for (int k = 0; k < 3; k++) begin
            exp_v[k] = 1'b0; exp_acc[k] = '0; exp_tag[k] = "R10";
        end
        rst_n = 1'b0; in_valid = 1'b1; clear = 1'b1;
        a_word = 32'h4000_4000; b_word = 32'h7FFF_8000;
        repeat (3) @(negedge clk);
        // R10: reset state even with valid operands applied
        checks++;
        if (out_valid !== 1'b0 || acc_word !== 32'd0) begin
            fails++;
            $display("FAIL R10: act %0b/%h exp 0/00000000", out_valid, acc_word);
        end
        in_valid = 1'b0; clear = 1'b0;
        rst_n = 1'b1;

        // R1 R2 R3: every pairing of extreme and mixed components, single-term sums
        for (int i0 = 0; i0 < 5; i0++)
            for (int i1 = 0; i1 < 5; i1++)
                for (int j0 = 0; j0 < 5; j0++)
                    for (int j1 = 0; j1 < 5; j1++)
                        step(1'b1, 1'b1, {aset[i0], aset[i1]}, {bset[j0], bset[j1]}, "R1 R2 R3");

        // R4: both ends of the multiplicand range
        step(1'b1, 1'b1, 32'h4000_C000, 32'h8000_7FFF, "R4");
        step(1'b1, 1'b0, 32'hC000_C000, 32'h8000_8000, "R4");
        step(1'b1, 1'b0, 32'h4000_4000, 32'h7FFF_7FFF, "R4");

        // R5 R6 R7 R11: accumulating groups with idle gaps and stray clears
        for (int g = 0; g < 60; g++) begin
            for (int t = 0; t < 7; t++) begin
                logic [31:0] a, b;
                seed = next_rand(seed); a[31:16] = rand_a(seed);
                seed = next_rand(seed); a[15:0]  = rand_a(seed);
                seed = next_rand(seed); b = seed;
                step(1'b1, (t == 0), a, b, (t == 0) ? "R6" : "R5");
                seed = next_rand(seed);
                if (seed[3:2] == 2'd0) step(1'b0, 1'b1, a, b, "R7");
                else if (seed[3:2] == 2'd1) step(1'b0, 1'b0, ~a, ~b, "R11");
            end
        end

        // R8: back-to-back accumulation into a long run, then drain with idle cycles
        for (int t = 0; t < 40; t++)
            step(1'b1, (t == 0), 32'h3FFF_C001, 32'h7FFF_1234, "R8");
        for (int t = 0; t < 6; t++)
            step(1'b0, 1'b0, 32'hDEAD_BEEF, 32'hCAFE_F00D, "R9");
        finish_run();
    end

endmodule